// File: doc/BRIEF.md
# Scan Pattern Watermark Checker

This block guards a scan test port against unauthorised use. Every test pattern shifted into the scan chain must carry an authentication key in a fixed window of shift positions. The key expected for a pattern is not constant: a linear feedback shift register moves it one step at every pattern boundary. A replayed or forged pattern therefore fails the check.

The block watches the scan-enable request and the serial scan-in bit on the scan clock. A shift counter tracks the position inside the current pattern. A comparator checks each bit that lands inside the key window against the expected key bit. A pattern that is abandoned part-way through counts as a failure too. Any failure sets a sticky alarm, and the alarm blocks the scan-enable that goes on to the scan chains.

Top module: `scan_wm_guard`

## Requirements
- R1: During and right after reset, `alarm` is 0, the shift position is 0 and the expected key equals the parameter `SEED` (default 8'hA5).
- R2: The shift position advances by one on each clock edge where `scan_en_in` is 1, holds where it is 0, and wraps to 0 after position `CHAIN_LEN-1`. One pattern is `CHAIN_LEN` shifts (default 32).
- R3: The bit sampled at shift position `KEY_POS+i`, for 0 <= i < `KEY_LEN`, must equal bit i of the expected key, least significant bit first (defaults `KEY_POS`=8, `KEY_LEN`=8).
- R4: Bits sampled outside the key window have no effect on `alarm`.
- R5: The first pattern after reset uses `SEED`. At each wrap the key steps to `(k >> 1) ^ (k[0] ? TAPS : 0)`, with `TAPS` defaulting to 8'hB8. A pattern that carries the previous pattern's key fails.
- R6: A key mismatch sampled at a clock edge makes `alarm` 1 right after that edge.
- R7: Once `alarm` is 1 it stays 1 until reset.
- R8: `scan_en_out` equals `scan_en_in` while `alarm` is 0, and is 0 while `alarm` is 1.
- R9: A clock edge with `scan_en_in` at 0 while the shift position is not 0 (a cut-short pattern) sets `alarm`. At position 0, `scan_en_in` at 0 is an idle gap and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_in | input | 1 | Serial scan data entering the chain |
| scan_en_in | input | 1 | Scan-enable request from the test controller |
| scan_en_out | output | 1 | Scan-enable passed to the chains, blocked by the alarm |
| alarm | output | 1 | Sticky authentication failure flag |

## Verification
A shift counter that is off by one position moves the key window, and an expected-key register on the wrong step fails the whole key. In both cases a correct pattern raises `alarm` at the first window bit that differs, within one pattern of the fault. A counter that wraps at the wrong length shows up at the next pattern boundary: the window lands in the wrong place, or the closing idle gap is seen as a cut-short pattern. An alarm that clears, or a gate that leaks, shows at `scan_en_out` on the next clock cycle where `scan_en_in` is 1.

// File: rtl/scan_wm_pkg.sv
package scan_wm_pkg;

  typedef struct packed {
    logic mismatch;   // key bit differs inside the window
    logic truncated;  // enable dropped mid-pattern
  } wm_evt_t;

  // true when shift position p lies in the key window [lo, lo+len)
  function automatic logic in_window(input int p, input int lo, input int len);
    return (p >= lo) && (p < lo + len);
  endfunction

endpackage

// File: rtl/wm_shift_counter.sv
module wm_shift_counter #(
  parameter int CHAIN_LEN = 32,
  localparam int PW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  output logic [PW-1:0] pos,
  output logic          wrap
);

  localparam logic [PW-1:0] LAST = PW'(CHAIN_LEN - 1);

  assign wrap = shift_en && (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (wrap)     pos <= '0;
    else if (shift_en) pos <= pos + 1'b1;
  end

  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(pos));
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pos == '0));
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < CHAIN_LEN);

endmodule

// File: rtl/wm_key_lfsr.sv
module wm_key_lfsr #(
  parameter int                KEY_LEN = 8,
  parameter logic [KEY_LEN-1:0] SEED   = 8'hA5,
  parameter logic [KEY_LEN-1:0] TAPS   = 8'hB8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [KEY_LEN-1:0] key
);

  function automatic logic [KEY_LEN-1:0] step(input logic [KEY_LEN-1:0] k);
    return (k >> 1) ^ (k[0] ? TAPS : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key <= SEED;
    else if (advance) key <= step(key);
  end

  assert_key_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(key));
  assert_key_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (key != $past(key)));
  assert_key_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key != '0);

endmodule

// File: rtl/wm_key_cmp.sv
module wm_key_cmp
  import scan_wm_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int KEY_POS   = 8,
  parameter int KEY_LEN   = 8,
  localparam int PW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int KW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
  input  logic               shift_en,
  input  logic               scan_in,
  input  logic [PW-1:0]      pos,
  input  logic [KEY_LEN-1:0] key,
  output wm_evt_t            evt
);

  logic          win;
  logic [PW-1:0] off;
  logic [KW-1:0] idx;

  assign win = in_window(int'(pos), KEY_POS, KEY_LEN);
  assign off = pos - PW'(KEY_POS);
  assign idx = off[KW-1:0];

  always_comb begin
    evt.mismatch  = shift_en && win && (scan_in != key[idx]);
    evt.truncated = !shift_en && (pos != '0);
  end

endmodule

// File: rtl/scan_wm_guard.sv
module scan_wm_guard
  import scan_wm_pkg::*;
#(
  parameter int          CHAIN_LEN = 32,
  parameter int          KEY_POS   = 8,
  parameter int          KEY_LEN   = 8,
  parameter logic [KEY_LEN-1:0] SEED = 8'hA5,
  parameter logic [KEY_LEN-1:0] TAPS = 8'hB8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_in,
  input  logic scan_en_in,
  output logic scan_en_out,
  output logic alarm
);

  localparam int PW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;

  logic [PW-1:0]      pos;
  logic               wrap;
  logic [KEY_LEN-1:0] key;
  wm_evt_t            evt;
  logic               fail_ev;

  wm_shift_counter #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .shift_en(scan_en_in), .pos(pos), .wrap(wrap));

  wm_key_lfsr #(.KEY_LEN(KEY_LEN), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(wrap), .key(key));

  wm_key_cmp #(.CHAIN_LEN(CHAIN_LEN), .KEY_POS(KEY_POS), .KEY_LEN(KEY_LEN)) u_cmp (
    .shift_en(scan_en_in), .scan_in(scan_in), .pos(pos), .key(key), .evt(evt));

  assign fail_ev = evt.mismatch || evt.truncated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alarm <= 1'b0;
    else if (fail_ev) alarm <= 1'b1;
  end

  assign scan_en_out = scan_en_in && !alarm;

  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);
  assert_alarm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(fail_ev));
  assert_event_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> alarm);
  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> !scan_en_out);

endmodule

// File: tb/scan_wm_guard_bench.sv
module scan_wm_guard_bench;

  localparam int N    = 32;
  localparam int KP   = 8;
  localparam int KL   = 8;
  localparam logic [7:0] SEED = 8'hA5;
  localparam logic [7:0] TAPS = 8'hB8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 1'b0;
  logic scan_en_in = 1'b0;
  logic scan_en_out, alarm;

  always #4 clk = ~clk;

  scan_wm_guard u_scan_wm_guard (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_en_in(scan_en_in),
    .scan_en_out(scan_en_out), .alarm(alarm));

  typedef struct {
    logic  alarm_x;
    logic  en_x;
    string tag;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model state
  logic       m_alarm;
  int         m_pos;
  logic [7:0] m_key, m_prev;

  function automatic logic [7:0] model_next(input logic [7:0] k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = ((i < 7) ? k[i+1] : 1'b0) ^ (k[0] & TAPS[i]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " alarm"}, alarm, it.alarm_x);
        check({it.tag, " R8 scan_en_out"}, scan_en_out, it.en_x);
      end
    end
  end

  // driver: one clock of stimulus, model update, push expectation
  task automatic drive(input logic en, input logic b, input string tag);
    @(negedge clk);
    scan_en_in = en;
    scan_in    = b;
    if (en) begin
      if (m_pos >= KP && m_pos < KP + KL && b != m_key[m_pos-KP]) m_alarm = 1'b1;
      if (m_pos == N - 1) begin
        m_pos  = 0;
        m_prev = m_key;
        m_key  = model_next(m_key);
      end else m_pos++;
    end else if (m_pos != 0) m_alarm = 1'b1;
    q.push_back('{m_alarm, en & ~m_alarm, tag});
  endtask

  // one pattern; flip_at flips that bit, stop_at drops enable there, stale uses old key
  task automatic pattern(input int flip_at, input int stop_at, input bit stale,
                         input string tag);
    logic [7:0] k;
    k = stale ? m_prev : m_key;
    for (int p = 0; p < N; p++) begin
      logic b;
      if (p == stop_at) begin
        drive(1'b0, 1'b0, tag);
        return;
      end
      b = (p >= KP && p < KP + KL) ? k[p-KP] : 1'($urandom_range(0, 1));
      if (p == flip_at) b = ~b;
      drive(1'b1, b, tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    scan_en_in = 1'b0;
    scan_in = 1'b0;
    m_alarm = 1'b0; m_pos = 0; m_key = SEED; m_prev = SEED;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state at the ports
    @(negedge clk);
    check("R1 alarm after reset", alarm, 1'b0);
    scan_en_in = 1'b1;
    #1 check("R1 R8 enable passes after reset", scan_en_out, 1'b1);
    scan_en_in = 1'b0;

    // idle gaps at position 0, then several good patterns (R2 R3 R4 R5 R9)
    drive(1'b0, 1'b1, "R9 idle gap");
    drive(1'b0, 1'b0, "R9 idle gap");
    for (int i = 0; i < 5; i++) begin
      pattern(-1, -1, 1'b0, "R2 R3 R4 R5 good pattern");
      drive(1'b0, 1'b1, "R9 idle between patterns");
    end
    pattern(-1, -1, 1'b0, "R2 back-to-back pattern");
    pattern(-1, -1, 1'b0, "R2 back-to-back pattern");

    // first window bit wrong in second pattern (R3 R6 R7 R8)
    do_reset();
    pattern(-1, -1, 1'b0, "R3 good");
    pattern(KP, -1, 1'b0, "R6 R7 first key bit flipped");
    pattern(-1, -1, 1'b0, "R7 alarm stays");

    // last window bit wrong (R3 R6)
    do_reset();
    pattern(KP + KL - 1, -1, 1'b0, "R3 R6 last key bit flipped");

    // bit just outside both edges of window flipped: no effect (R4)
    do_reset();
    pattern(KP - 1, -1, 1'b0, "R4 bit before window");
    pattern(KP + KL, -1, 1'b0, "R4 bit after window");

    // replayed key (R5)
    do_reset();
    pattern(-1, -1, 1'b0, "R5 good");
    pattern(-1, -1, 1'b1, "R5 stale key replay");

    // truncated pattern (R9)
    do_reset();
    pattern(-1, 5, 1'b0, "R9 cut short");
    drive(1'b1, 1'b0, "R7 R8 gate after truncation");

    // key mismatch with an all-zero window (R3)
    do_reset();
    for (int p = 0; p < KP + KL; p++) drive(1'b1, 1'b0, "R3 zero key rejected");

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    check("R7 alarm still set at end", alarm, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule